// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single timer channel that counts down from a programmable value and reloads itself automatically. A prescaler divides the peripheral clock by a power of four chosen by a 3-bit code. Each prescaler tick decrements a 32-bit counter. A tick that finds the counter at zero is the underflow event: it refills the counter from a 32-bit reload register and raises a sticky underflow flag. While the interrupt enable bit is set, that flag drives a level interrupt. A plain `run` input starts and pauses counting.

Software reaches the channel through a word-addressed register port. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`. The port has no handshake and no back-pressure, so an access is accepted on every cycle. Software clears the flag by writing the control word with the flag bit at zero. An optional capture register can be included at build time. Input-capture sampling and external clock edge selection are not built.

Top module: `dctimer_channel`

## Requirements
- R1: After reset, the reload and counter registers hold 0xFFFFFFFF, the stored control bits and the underflow flag are 0, `irq` is low, and the capture register (when built) holds 0.
- R2: Word address 0 selects the reload register, 1 the counter, 2 the control word and 3 the capture register. `bus_rdata` shows the register that `bus_addr` selects in the same cycle, and control reads return 0 in bits [31:16].
- R3: While `run` is high, control code bits [2:0] values 0, 1, 2, 3 and 4 produce one counter tick every 4, 16, 64, 256 and 1024 clocks respectively. Codes 5, 6 and 7 produce no ticks. While `run` is low, the prescaler phase and the counter hold.
- R4: A control write that changes the code in bits [2:0] restarts the prescaler phase at zero. No tick happens in that cycle, and the first tick under the new code comes a full divisor later.
- R5: A tick decrements the counter by one. A tick with the counter at 0 loads the counter from the reload register and sets the underflow flag.
- R6: A write to the counter loads the written value and overrides any decrement or reload in that cycle. It also suppresses the underflow in that cycle. A write to the reload register leaves the counter alone, and an underflow in the same cycle loads the old reload value.
- R7: A control write with bit 8 = 0 clears the underflow flag, and a write with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: A control read returns the live underflow flag in bit 8. Control bits [15:10] are ignored on write and read as 0.
- R9: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R10: With `HAS_CAPTURE` = 1, address 3 is read/write and control bits [7:6] and 9 are stored. With `HAS_CAPTURE` = 0, address 3 reads 0 and ignores writes, and control bits [7:6] and 9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable; low pauses prescaler and counter |
| bus_wr | input | 1 | Register write strobe, taken at the clock edge |
| bus_addr | input | 2 | Word address of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: underflow flag AND enable |

## Verification
The assertions assume that the inputs are stable across the sampling edge and are free of X once reset is released. They also assume that `bus_addr` is always one of the four defined words. The tick-spacing property relies on the smallest divisor being four, so two ticks can never occur on adjacent clocks. The stimulus changes the inputs only on the falling edge and uses only legal addresses. To hit the same-cycle collisions, it repeats counter, reload and flag-clearing writes on every cycle around an underflow. It also runs a capture-less copy of the channel alongside the main one.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CTRL_W   = 16;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;
  localparam int IE_BIT   = 5;
  localparam int UF_BIT   = 8;
  localparam logic [1:0] ADR_RELOAD = 2'd0;
  localparam logic [1:0] ADR_COUNT  = 2'd1;
  localparam logic [1:0] ADR_CTRL   = 2'd2;
  localparam logic [1:0] ADR_CAPT   = 2'd3;
  localparam logic [CTRL_W-1:0] BASE_MASK = 16'h003F;
  localparam logic [CTRL_W-1:0] CAPT_MASK = 16'h02C0;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              tick
);
  localparam int PH_W = 2 * MAX_CODE + 2;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_phase;
  logic            code_ok;

  always_comb begin
    code_ok    = int'(code) <= MAX_CODE;
    last_phase = '0;
    if (code_ok)
      last_phase = {PH_W{1'b1}} >> (PH_W - 2 * int'(code) - 2);
  end

  assign tick = run && code_ok && !restart && (phase_q == last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n)                phase_q <= '0;
    else if (restart)          phase_q <= '0;
    else if (run && code_ok)   phase_q <= tick ? '0 : phase_q + PH_W'(1);
  end

  // R3: smallest divisor is four, so ticks never sit on adjacent clocks
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R4: the cycle after a restart cannot tick
  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             rel_wr,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             flag_q
);
  logic underflow;
  assign underflow = tick && !cnt_wr && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      reload_q <= '1;
      flag_q   <= 1'b0;
    end else begin
      if (rel_wr) reload_q <= wdata;
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - CNT_W'(1);
      if (underflow)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q == '0) |=> (flag_q && cnt_q == $past(reload_q)));
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q == '0 && flag_clr) |=> flag_q);
endmodule

// File: rtl/dctimer_channel.sv
module dctimer_channel #(
  parameter int CNT_W       = 32,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import dct_pkg::*;

  localparam logic [CTRL_W-1:0] STORE_MASK = HAS_CAPTURE ? (BASE_MASK | CAPT_MASK) : BASE_MASK;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, reload_q, cap_rd;
  logic              flag_q, tick, ctrl_wr, code_chg, flag_clr;

  assign ctrl_wr  = bus_wr && (bus_addr == ADR_CTRL);
  assign code_chg = ctrl_wr && (bus_wdata[CODE_W-1:0] != ctrl_q[CODE_W-1:0]);
  assign flag_clr = ctrl_wr && !bus_wdata[UF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0] & STORE_MASK;
  end

  dct_prescaler #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run),
    .code(ctrl_q[CODE_W-1:0]), .restart(code_chg), .tick(tick)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_wr(bus_wr && bus_addr == ADR_COUNT),
    .rel_wr(bus_wr && bus_addr == ADR_RELOAD),
    .flag_clr(flag_clr), .wdata(bus_wdata[CNT_W-1:0]),
    .cnt_q(cnt_q), .reload_q(reload_q), .flag_q(flag_q)
  );

  generate
    if (HAS_CAPTURE) begin : g_capt
      logic [CNT_W-1:0] cap_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                               cap_q <= '0;
        else if (bus_wr && bus_addr == ADR_CAPT)  cap_q <= bus_wdata[CNT_W-1:0];
      end
      assign cap_rd = cap_q;
    end else begin : g_nocapt
      assign cap_rd = '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_RELOAD: bus_rdata = 32'(reload_q);
      ADR_COUNT:  bus_rdata = 32'(cnt_q);
      ADR_CTRL: begin
        bus_rdata[CTRL_W-1:0] = ctrl_q;
        bus_rdata[UF_BIT]     = flag_q;
      end
      default:    bus_rdata = 32'(cap_rd);
    endcase
  end

  assign irq = flag_q && ctrl_q[IE_BIT];

  assert_resv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_CTRL) |-> (bus_rdata[31:10] == '0));
  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[IE_BIT]) |=> !irq);
  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[UF_BIT] && flag_q) |=> flag_q);
endmodule

// File: tb/dctimer_channel_tb.sv
module dctimer_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_rel = 32'hFFFF_FFFF, m_cnt = 32'hFFFF_FFFF, m_cap = '0;
  logic [15:0] m_ctrl = '0;
  bit          m_flag = 1'b0;
  int          m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctimer_channel u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .irq(irq_a));

  dctimer_channel #(.HAS_CAPTURE(1'b0)) u_dut_nc (
    .clk(clk), .rst_n(rst_n), .run(run), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .irq(irq_b));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] a, input bit capt);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: v = m_rel;
      2'd1: v = m_cnt;
      2'd2: begin
        v[15:0] = m_ctrl & (capt ? 16'h02FF : 16'h003F);
        v[8] = m_flag;
      end
      default: v = capt ? m_cap : 32'h0;
    endcase
    return v;
  endfunction

  task automatic model_step(input bit r, input bit w, input logic [1:0] a, input logic [31:0] d);
    int  code, period;
    bit  tk, uf, cw;
    logic [31:0] old_rel;
    code   = int'(m_ctrl[2:0]);
    period = 1 << (2 * code + 2);
    cw     = w && a == 2'd1;
    tk     = 1'b0;
    if (w && a == 2'd2 && d[2:0] != m_ctrl[2:0]) m_phase = 0;
    else if (r && code <= 4) begin
      m_phase++;
      if (m_phase == period) begin tk = 1'b1; m_phase = 0; end
    end
    uf = tk && !cw && m_cnt == 0;
    old_rel = m_rel;
    if (w) begin
      if (a == 2'd0) m_rel = d;
      if (a == 2'd1) m_cnt = d;
      if (a == 2'd2) m_ctrl = d[15:0] & 16'h02FF;
      if (a == 2'd3) m_cap = d;
    end
    if (!cw && tk) m_cnt = (m_cnt == 0) ? old_rel : m_cnt - 1;
    if (uf) m_flag = 1'b1;
    else if (w && a == 2'd2 && !d[8]) m_flag = 1'b0;
  endtask

  task automatic cyc(input bit r, input bit w, input logic [1:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    run = r; bus_wr = w; bus_addr = a; bus_wdata = d;
    model_step(r, w, a, d);
    @(posedge clk);
    #1;
    check({req, " rdata"}, rd_a, exp_read(a, 1'b1));
    check({req, " rdata nocapt R10"}, rd_b, exp_read(a, 1'b0));
    check({req, " irq R9"}, {31'b0, irq_a}, {31'b0, m_flag && m_ctrl[5]});
    check({req, " irq nocapt R9"}, {31'b0, irq_b}, {31'b0, m_flag && m_ctrl[5]});
  endtask

  task automatic idle(input bit r, input logic [1:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) cyc(r, 1'b0, a, 32'h0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) idle(1'b0, 2'(a), 1, "R1 reset");
    // R2 map, R8 reserved bits, R10 capture register
    cyc(0, 1, 2'd0, 32'd5, "R2 reload");
    cyc(0, 1, 2'd1, 32'd3, "R2 count");
    cyc(0, 1, 2'd3, 32'h1234_5678, "R10 capture");
    cyc(0, 1, 2'd2, 32'hFFFF_FCE0, "R8 reserved");
    idle(0, 2'd2, 1, "R8 readback");
    idle(0, 2'd3, 1, "R10 readback");
    // R3 R5 code 0 counting with underflow and irq
    cyc(0, 1, 2'd2, 32'h0000_0020, "R5 setup");
    idle(1, 2'd1, 40, "R3 R5 code0");
    idle(1, 2'd2, 4, "R8 live flag");
    // R7 write-one keeps, write-zero clears
    cyc(1, 1, 2'd2, 32'h0000_0120, "R7 keep");
    cyc(1, 1, 2'd2, 32'h0000_0020, "R7 clear");
    // R4 code change mid-run
    idle(1, 2'd1, 2, "R4 pre");
    cyc(1, 1, 2'd2, 32'h0000_0021, "R4 change");
    idle(1, 2'd1, 70, "R4 code1");
    // R3 larger divisors
    cyc(1, 1, 2'd2, 32'h0000_0022, "R3 code2");
    idle(1, 2'd1, 140, "R3 code2 run");
    cyc(1, 1, 2'd1, 32'd2, "R3 code3 load");
    cyc(1, 1, 2'd2, 32'h0000_0023, "R3 code3");
    idle(1, 2'd1, 800, "R3 code3 run");
    cyc(1, 1, 2'd1, 32'd1, "R3 code4 load");
    cyc(1, 1, 2'd2, 32'h0000_0024, "R3 code4");
    idle(1, 2'd1, 2100, "R3 code4 run");
    // R3 reserved and external codes
    for (int c = 5; c < 8; c++) begin
      cyc(1, 1, 2'd2, 32'(c) | 32'h20, "R3 nocode");
      idle(1, 2'd1, 40, "R3 nocode run");
    end
    // R3 pause with run low
    cyc(1, 1, 2'd2, 32'h0000_0020, "R3 pause setup");
    idle(1, 2'd1, 2, "R3 pre pause");
    idle(0, 2'd1, 20, "R3 paused");
    idle(1, 2'd1, 10, "R3 resume");
    // R6 counter writes collide with ticks at zero
    cyc(1, 1, 2'd2, 32'h0000_0020, "R6 clear");
    for (int i = 0; i < 12; i++) cyc(1, 1, 2'd1, 32'd0, "R6 cnt write");
    idle(1, 2'd2, 1, "R6 flag");
    // R6 reload writes around underflows
    cyc(1, 1, 2'd1, 32'd0, "R6 zero");
    for (int i = 0; i < 12; i++) cyc(1, 1, 2'd0, 32'(i + 1), "R6 rel write");
    idle(1, 2'd1, 12, "R6 after");
    // R7 clearing writes collide with underflows
    cyc(1, 1, 2'd0, 32'd0, "R7 rel0");
    for (int i = 0; i < 16; i++) cyc(1, 1, 2'd2, 32'h0000_0020, "R7 collide");
    // R9 enable off with flag set
    idle(1, 2'd2, 6, "R9 flag");
    cyc(1, 1, 2'd2, 32'h0000_0100, "R9 disable");
    idle(1, 2'd2, 6, "R9 off");
    cyc(1, 1, 2'd2, 32'h0000_0120, "R9 enable");
    idle(1, 2'd2, 4, "R9 on");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule